// File: doc/BRIEF.md
# Indexed Colour Palette with Byte-Wide Load Port

This block is a colour look-up table for a display pipeline. It stores 256 colours of 18 bits each, six bits per primary. On the pixel side, an 8-bit pixel index is ANDed with a host-programmed mask. The result addresses the table, and the stored colour appears on a registered output one clock later.

The host loads the table one byte at a time through three byte-wide registers, picked by a select code: the mask, a start index, and a single data location. The host first sets the start index. It then writes three bytes to the data location, in the order red, green, blue. Only the top six bits of each byte are kept. A small state machine tracks which colour the next data byte carries. It has three states: PH_RED, PH_GREEN and PH_BLUE.

The state machine moves as follows:
- A data write in PH_RED stores the red staging register and moves to PH_GREEN.
- A data write in PH_GREEN stores the green staging register and moves to PH_BLUE.
- A data write in PH_BLUE writes the full entry into the table, advances the index and returns to PH_RED.
- A start-index write returns the machine to PH_RED from any state.

Red and green wait in staging registers, so a half-loaded colour never reaches the pixel output. After a full triple the host can go straight on to the next entry without setting the index again.

Top module: `clut_palette`

## Requirements
- R1: After reset every table entry reads as 0. The mask is 8'hFF, the write index is 0 and the state machine is in PH_RED.
- R2: A host write takes effect only while host_we is 1. The select codes are: 0 writes the mask, 1 writes the start index, 2 writes the data location. Code 3, and any cycle with host_we at 0, changes no table entry, no index and no state.
- R3: Successive data writes carry red, then green, then blue. Each component is taken from bits [7:2] of host_wdata. The entry is stored as {red, green, blue}, with red in bits [17:12] and blue in bits [5:0].
- R4: The table entry changes only on the blue write. After red and green alone, the addressed entry still reads its old value.
- R5: After each blue write the index moves up by one, wrapping from 255 to 0, so the next triple fills the next entry.
- R6: A start-index write puts the state machine back in PH_RED and drops any staged red or green. The next three data bytes fill the newly written index.
- R7: The pixel output is registered. The colour for the index applied before a rising edge appears after that edge. Lookups on consecutive cycles each return their own entry.
- R8: The lookup address is pix_idx AND mask. With the mask at 8'hFF the pixel index passes through unchanged.
- R9: A new mask value applies to lookups from the clock edge after the mask write onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host byte write strobe |
| host_sel | input | 2 | Register select: 0 mask, 1 start index, 2 colour data, 3 none |
| host_wdata | input | 8 | Host write byte |
| pix_idx | input | 8 | Pixel colour index |
| pix_rgb | output | 18 | Looked-up colour {red, green, blue}, one cycle after pix_idx |

## Verification
Lookups are compared against a model of the table that the bench builds from its own host writes.

Several patterns are used:
- Distinct triples loaded back to back from one start index show that the index advances and that each colour lands in its own field.
- Bytes with their low two bits set show that only the top six bits are kept.
- A red-and-green-only sequence followed by a fresh start index separates commit-on-blue and the phase reset from a design that writes early or keeps stale staging.
- A load starting at 255 checks the wrap to 0.
- Select code 3 and strobe-low writes check that the index and phase are left untouched.
- Mask changes followed by lookups in the very next cycle check both the AND and when it takes effect.

// File: rtl/clut_pkg.sv
package clut_pkg;

    // Host register select codes
    typedef enum logic [1:0] {
        SEL_MASK  = 2'd0,
        SEL_INDEX = 2'd1,
        SEL_DATA  = 2'd2,
        SEL_NONE  = 2'd3
    } host_sel_e;

    // Colour component that the next data byte carries
    typedef enum logic [1:0] {
        PH_RED   = 2'd0,
        PH_GREEN = 2'd1,
        PH_BLUE  = 2'd2
    } phase_e;

endpackage

// File: rtl/clut_host_seq.sv
module clut_host_seq
    import clut_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int COMP_W = 6,
    parameter int BYTE_W = 8,
    localparam int RGB_W = 3 * COMP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [1:0]        host_sel,
    input  logic [BYTE_W-1:0] host_wdata,
    output logic [IDX_W-1:0]  mask_q,
    output logic              ram_we,
    output logic [IDX_W-1:0]  ram_addr,
    output logic [RGB_W-1:0]  ram_wdata
);

    phase_e              ph_q, ph_d;
    logic [IDX_W-1:0]    wr_idx_q;
    logic [COMP_W-1:0]   red_q, grn_q;
    logic [COMP_W-1:0]   comp_in;
    logic                mask_hit, index_hit, data_hit;

    assign mask_hit  = host_we && (host_sel == SEL_MASK);
    assign index_hit = host_we && (host_sel == SEL_INDEX);
    assign data_hit  = host_we && (host_sel == SEL_DATA);
    assign comp_in   = host_wdata[BYTE_W-1 -: COMP_W];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q <= PH_RED;
        end else begin
            ph_q <= ph_d;
        end
    end

    // Next state
    always_comb begin
        ph_d = ph_q;
        if (index_hit) begin
            ph_d = PH_RED;
        end else if (data_hit) begin
            unique case (ph_q)
                PH_RED:   ph_d = PH_GREEN;
                PH_GREEN: ph_d = PH_BLUE;
                PH_BLUE:  ph_d = PH_RED;
                default:  ph_d = PH_RED;
            endcase
        end
    end

    // Outputs toward the table
    always_comb begin
        ram_we    = 1'b0;
        ram_addr  = wr_idx_q;
        ram_wdata = {red_q, grn_q, comp_in};
        unique case (ph_q)
            PH_BLUE: ram_we = data_hit;
            default: ram_we = 1'b0;
        endcase
    end

    // Mask, index and staging registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q   <= '1;
            wr_idx_q <= '0;
            red_q    <= '0;
            grn_q    <= '0;
        end else begin
            if (mask_hit) begin
                mask_q <= host_wdata[IDX_W-1:0];
            end
            if (index_hit) begin
                wr_idx_q <= host_wdata[IDX_W-1:0];
            end else if (ram_we) begin
                wr_idx_q <= wr_idx_q + 1'b1;
            end
            if (data_hit && ph_q == PH_RED) begin
                red_q <= comp_in;
            end
            if (data_hit && ph_q == PH_GREEN) begin
                grn_q <= comp_in;
            end
        end
    end

    // R6: an index write always leaves the machine in PH_RED
    p_red_after_index_r6: assert property (@(posedge clk) disable iff (!rst_n)
        index_hit |=> (ph_q == PH_RED));

    // R3: red is followed by green
    p_phase_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (data_hit && ph_q == PH_RED) |=> (ph_q == PH_GREEN));

    // R5: a commit advances the index by one (wrapping)
    p_idx_advance_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |=> (wr_idx_q == $past(wr_idx_q) + 1'b1));

    // R2: no strobe, no change of index or phase
    p_idx_still_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !host_we |=> ($stable(wr_idx_q) && $stable(ph_q)));

    // R9: the mask only changes on a mask write
    p_mask_still_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_hit |=> $stable(mask_q));

endmodule

// File: rtl/clut_ram.sv
module clut_ram #(
    parameter int IDX_W  = 8,
    parameter int DATA_W = 18,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < DEPTH; e++) begin
                mem[e] <= '0;
            end
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else begin
            rdata <= mem[raddr];
        end
    end

endmodule

// File: rtl/clut_pix_mask.sv
module clut_pix_mask #(
    parameter int IDX_W = 8
) (
    input  logic [IDX_W-1:0] pix_idx,
    input  logic [IDX_W-1:0] mask,
    output logic [IDX_W-1:0] idx_out
);

    assign idx_out = pix_idx & mask;

endmodule

// File: rtl/clut_palette.sv
module clut_palette #(
    parameter int IDX_W  = 8,
    parameter int COMP_W = 6,
    parameter int BYTE_W = 8,
    localparam int RGB_W = 3 * COMP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [1:0]        host_sel,
    input  logic [BYTE_W-1:0] host_wdata,
    input  logic [IDX_W-1:0]  pix_idx,
    output logic [RGB_W-1:0]  pix_rgb
);

    logic [IDX_W-1:0] mask_q;
    logic             ram_we;
    logic [IDX_W-1:0] ram_addr;
    logic [RGB_W-1:0] ram_wdata;
    logic [IDX_W-1:0] rd_idx;

    clut_host_seq #(
        .IDX_W (IDX_W),
        .COMP_W(COMP_W),
        .BYTE_W(BYTE_W)
    ) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_we   (host_we),
        .host_sel  (host_sel),
        .host_wdata(host_wdata),
        .mask_q    (mask_q),
        .ram_we    (ram_we),
        .ram_addr  (ram_addr),
        .ram_wdata (ram_wdata)
    );

    clut_pix_mask #(
        .IDX_W(IDX_W)
    ) i_mask (
        .pix_idx(pix_idx),
        .mask   (mask_q),
        .idx_out(rd_idx)
    );

    clut_ram #(
        .IDX_W (IDX_W),
        .DATA_W(RGB_W)
    ) i_ram (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (ram_we),
        .waddr(ram_addr),
        .wdata(ram_wdata),
        .raddr(rd_idx),
        .rdata(pix_rgb)
    );

endmodule

// File: tb/test_clut_palette.sv
module test_clut_palette;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [1:0]  host_sel = 2'd3;
    logic [7:0]  host_wdata = 8'h00;
    logic [7:0]  pix_idx = 8'h00;
    logic [17:0] pix_rgb;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // Bench model, built from the requirements
    logic [17:0] model [256];
    logic [7:0]  m_mask = 8'hFF;
    logic [7:0]  m_idx = 8'h00;
    int          m_ph = 0;
    logic [5:0]  m_r = 6'd0, m_g = 6'd0;

    logic [17:0] q_exp [$];
    string       q_tag [$];

    always #4 clk = ~clk;

    clut_palette i_clut_palette (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_we   (host_we),
        .host_sel  (host_sel),
        .host_wdata(host_wdata),
        .pix_idx   (pix_idx),
        .pix_rgb   (pix_rgb)
    );

    task automatic host_write(input logic we, input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        host_we = we;
        host_sel = sel;
        host_wdata = d;
        if (we) begin
            case (sel)
                2'd0: m_mask = d;
                2'd1: begin m_idx = d; m_ph = 0; end
                2'd2: begin
                    if (m_ph == 0) begin m_r = d[7:2]; m_ph = 1; end
                    else if (m_ph == 1) begin m_g = d[7:2]; m_ph = 2; end
                    else begin
                        model[m_idx] = {m_r, m_g, d[7:2]};
                        m_idx = m_idx + 8'd1;
                        m_ph = 0;
                    end
                end
                default: ;
            endcase
        end
        @(posedge clk);
        #1;
        host_we = 1'b0;
        host_sel = 2'd3;
    endtask

    task automatic triple(input logic [7:0] r, input logic [7:0] g, input logic [7:0] b);
        host_write(1'b1, 2'd2, r);
        host_write(1'b1, 2'd2, g);
        host_write(1'b1, 2'd2, b);
    endtask

    // Driver: apply index, push expected colour
    task automatic lookup(input logic [7:0] idx, input string tag);
        @(negedge clk);
        pix_idx = idx;
        q_exp.push_back(model[idx & m_mask]);
        q_tag.push_back(tag);
    endtask

    // Monitor: one result per rising edge after a pushed lookup
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q_exp.size() > 0) begin
                logic [17:0] e;
                string t;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                total++;
                if (pix_rgb !== e) begin
                    bad++;
                    $display("FAIL %s: pix_rgb=%h expected=%h", t, pix_rgb, e);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish, got hung expected done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) model[i] = 18'd0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset contents are zero, mask passes all bits
        lookup(8'h00, "R1 reset entry 00");
        lookup(8'hA5, "R1 reset entry A5");

        // R3 R5: three triples from index 0x10, back to back
        host_write(1'b1, 2'd1, 8'h10);
        triple(8'h04, 8'h08, 8'h0C);
        triple(8'hFC, 8'h00, 8'hA8);
        triple(8'h54, 8'hAC, 8'h30);
        lookup(8'h10, "R3 entry 10");
        lookup(8'h11, "R3 field order entry 11");
        lookup(8'h12, "R5 auto advance entry 12");
        // R7: consecutive lookups each return their own entry
        lookup(8'h10, "R7 back to back a");
        lookup(8'h12, "R7 back to back b");

        // R3: low two bits dropped
        host_write(1'b1, 2'd1, 8'h13);
        triple(8'hFF, 8'h83, 8'h07);
        lookup(8'h13, "R3 top six bits only");

        // R4: red and green alone do not change entry 0x20
        host_write(1'b1, 2'd1, 8'h20);
        host_write(1'b1, 2'd2, 8'hF0);
        host_write(1'b1, 2'd2, 8'h70);
        lookup(8'h20, "R4 no partial commit");
        // R6: new start index restarts at red
        host_write(1'b1, 2'd1, 8'h21);
        triple(8'h18, 8'h28, 8'h38);
        lookup(8'h21, "R6 restart at red");
        lookup(8'h20, "R6 dropped stage");
        triple(8'h40, 8'h44, 8'h48);
        lookup(8'h22, "R5 continue after restart");

        // R5: wrap from 255 to 0
        host_write(1'b1, 2'd1, 8'hFF);
        triple(8'h80, 8'h84, 8'h88);
        triple(8'h90, 8'h94, 8'h98);
        triple(8'hA0, 8'hA4, 8'hA8);
        triple(8'hB0, 8'hB4, 8'hB8);
        lookup(8'hFF, "R5 entry FF");
        lookup(8'h00, "R5 wrap to 00");
        lookup(8'h02, "R5 entry 02");

        // R2: select 3 and strobe-low writes are ignored
        host_write(1'b1, 2'd3, 8'hEC);
        host_write(1'b0, 2'd2, 8'hDC);
        host_write(1'b0, 2'd1, 8'h40);
        host_write(1'b1, 2'd3, 8'hCC);
        triple(8'h0C, 8'h1C, 8'h2C);
        lookup(8'h03, "R2 ignored writes kept index and phase");
        lookup(8'h40, "R2 ignored index write");
        host_write(1'b0, 2'd0, 8'h00);
        lookup(8'h13, "R2 strobe-low mask write ignored");

        // R8 R9: mask applied from the next edge
        host_write(1'b1, 2'd0, 8'h0F);
        lookup(8'h12, "R9 mask 0F first lookup");
        lookup(8'hF3, "R8 mask 0F gives entry 03");
        lookup(8'h10, "R8 mask 0F gives entry 00");
        host_write(1'b1, 2'd0, 8'hFF);
        lookup(8'h12, "R8 full mask passes index");
        lookup(8'hFF, "R8 full mask entry FF");

        repeat (4) @(posedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule